// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block chooses which of eleven interrupt sources a small 8-bit processor core should service next. Each source brings a pending flag from its peripheral, an enable bit and a level bit that selects low or high priority. A global enable gates all of them. The controller compares the requests every clock. When the core signals an instruction boundary and a request is allowed to run, the controller presents a vector address and a take-interrupt strobe. Both are held until the core accepts the call.

A two-bit in-service register records which levels have an active service routine. A high-level request may interrupt a low-level routine. Nothing interrupts a high-level routine, and a low-level request waits until no routine is active. When a return-from-interrupt completes, the controller requires one further instruction to complete before it starts another call. The controller never clears a pending flag; the peripheral or software does that.

The control state machine has three states:
- `ST_IDLE`: waits for work.
- `ST_CALL`: the strobe is raised and the vector is held.
- `ST_GAP`: a return has just completed.

The transitions are:
- IDLE→CALL: an instruction boundary with an eligible winner, and no return in that cycle.
- IDLE→GAP: a return completes.
- CALL→IDLE: the core accepts the call.
- GAP→GAP: another return completes.
- GAP→CALL: the next boundary with an eligible winner.
- GAP→IDLE: the next boundary with no eligible winner.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, `take_irq` is 0, `in_svc` is 2'b00 and `vec_addr` is 16'h0000.
- R2: A source takes part in arbitration only if `glb_en`, its `req_pend` bit and its `req_en` bit are all 1. Source index 8 never takes part.
- R3: A participating source with its `req_hi` bit set wins over every participating source with the bit clear, whatever their indices.
- R4: Among participating sources of the same level, the one with the smallest index wins.
- R5: The vector presented for source index i is 16'h0003 + 8*i, giving 16'h0003 for index 0 up to 16'h0053 for index 10.
- R6: A call is started only on a cycle where `insn_bound` is 1. `take_irq` rises in the cycle after that boundary.
- R7: While `take_irq` is 1 and `call_ack` is 0, `take_irq` stays 1 and `vec_addr` stays unchanged, even if the request is withdrawn. `take_irq` is 0 in the cycle after `call_ack`.
- R8: When a call is accepted, the bit of `in_svc` for the winner's level is set. Bit 0 is low and bit 1 is high.
- R9: A high-level request is not started while `in_svc[1]` is 1. A low-level request is not started while any bit of `in_svc` is 1. A high-level request is started while only `in_svc[0]` is 1.
- R10: On `reti_done`, the highest set bit of `in_svc` is cleared and any lower bit is kept.
- R11: A boundary in the same cycle as `reti_done` never starts a call. The first boundary after it may start one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| glb_en | input | 1 | Global enable for all sources |
| req_pend | input | 11 | Pending flags from the peripherals, one per source index |
| req_en | input | 11 | Per-source enable bits |
| req_hi | input | 11 | Per-source level bits, 1 = high |
| insn_bound | input | 1 | One-cycle strobe: an instruction has completed |
| reti_done | input | 1 | One-cycle strobe: a return-from-interrupt has completed |
| call_ack | input | 1 | One-cycle strobe: the core has accepted the call |
| take_irq | output | 1 | Request to the core to call `vec_addr` |
| vec_addr | output | 16 | Vector address of the selected source |
| in_svc | output | 2 | Levels with an active service routine (bit 1 high, bit 0 low) |

## Verification
The properties rely on the core following the handshake. `call_ack` appears only while `take_irq` is high. `reti_done` appears only while some routine is in service and no call is outstanding. Every strobe lasts a single cycle. The bench drives the core signals from tasks that follow exactly these rules: they acknowledge only a raised strobe and issue returns only for routines that were accepted, so the bench never relies on the controller's response to an illegal handshake.

// File: rtl/irq_pkg.sv
package irq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CALL = 2'd1,
        ST_GAP  = 2'd2
    } ctl_state_t;

    localparam int LVL_LO = 0;
    localparam int LVL_HI = 1;
    localparam int NUM_LVL = 2;

endpackage

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int N     = 11,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0]     req,
    output logic             valid,
    output logic [IDX_W-1:0] idx
);

    // lowest index wins: scan from the top so the last hit is the smallest
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                valid = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_arb.sv
module irq_arb #(
    parameter int N       = 11,
    parameter int IDX_W   = 4,
    parameter int RSV_IDX = 8
) (
    input  logic             glb_en,
    input  logic [N-1:0]     req_pend,
    input  logic [N-1:0]     req_en,
    input  logic [N-1:0]     req_hi,
    output logic             win_valid,
    output logic [IDX_W-1:0] win_idx,
    output logic             win_hi
);
    import irq_pkg::*;

    localparam logic [N-1:0] RSV_MASK = N'(1) << RSV_IDX;

    logic [N-1:0]     active;
    logic [N-1:0]     lvl_req [NUM_LVL];
    logic             lvl_vld [NUM_LVL];
    logic [IDX_W-1:0] lvl_idx [NUM_LVL];

    assign active = req_pend & req_en & {N{glb_en}} & ~RSV_MASK;

    generate
        for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
            if (l == LVL_HI) begin : g_hi
                assign lvl_req[l] = active & req_hi;
            end else begin : g_lo
                assign lvl_req[l] = active & ~req_hi;
            end
            irq_pick #(.N(N), .IDX_W(IDX_W)) u_pick (
                .req   (lvl_req[l]),
                .valid (lvl_vld[l]),
                .idx   (lvl_idx[l])
            );
        end
    endgenerate

    always_comb begin
        win_hi    = lvl_vld[LVL_HI];
        win_valid = lvl_vld[LVL_HI] | lvl_vld[LVL_LO];
        win_idx   = lvl_vld[LVL_HI] ? lvl_idx[LVL_HI] : lvl_idx[LVL_LO];
    end

endmodule

// File: rtl/irq_svc_track.sv
module irq_svc_track (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_en,
    input  logic       set_hi,
    input  logic       clr_en,
    output logic [1:0] in_svc
);
    import irq_pkg::*;

    logic [1:0] svc_q;
    logic [1:0] svc_d;

    always_comb begin
        svc_d = svc_q;
        if (clr_en) begin
            if (svc_q[LVL_HI]) svc_d[LVL_HI] = 1'b0;
            else               svc_d[LVL_LO] = 1'b0;
        end
        if (set_en) begin
            if (set_hi) svc_d[LVL_HI] = 1'b1;
            else        svc_d[LVL_LO] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) svc_q <= 2'b00;
        else        svc_q <= svc_d;
    end

    assign in_svc = svc_q;

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
    parameter int              NUM_SRC  = 11,
    parameter int              RSV_IDX  = 8,
    parameter int              VEC_W    = 16,
    parameter logic [VEC_W-1:0] VEC_BASE = 16'h0003,
    parameter logic [VEC_W-1:0] VEC_STEP = 16'h0008
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               glb_en,
    input  logic [NUM_SRC-1:0] req_pend,
    input  logic [NUM_SRC-1:0] req_en,
    input  logic [NUM_SRC-1:0] req_hi,
    input  logic               insn_bound,
    input  logic               reti_done,
    input  logic               call_ack,
    output logic               take_irq,
    output logic [VEC_W-1:0]   vec_addr,
    output logic [1:0]         in_svc
);
    import irq_pkg::*;

    localparam int IDX_W = $clog2(NUM_SRC);

    ctl_state_t       state_q;
    ctl_state_t       state_d;
    logic             win_valid;
    logic [IDX_W-1:0] win_idx;
    logic             win_hi;
    logic             eligible;
    logic             load_call;
    logic [VEC_W-1:0] vec_q;
    logic             lvl_hi_q;
    logic [VEC_W-1:0] vec_calc;

    irq_arb #(.N(NUM_SRC), .IDX_W(IDX_W), .RSV_IDX(RSV_IDX)) u_arb (
        .glb_en    (glb_en),
        .req_pend  (req_pend),
        .req_en    (req_en),
        .req_hi    (req_hi),
        .win_valid (win_valid),
        .win_idx   (win_idx),
        .win_hi    (win_hi)
    );

    irq_svc_track u_svc (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (state_q == ST_CALL && call_ack),
        .set_hi (lvl_hi_q),
        .clr_en (reti_done && state_q != ST_CALL),
        .in_svc (in_svc)
    );

    // high may nest over low; low only runs with nothing in service
    assign eligible = win_valid &&
                      (win_hi ? !in_svc[LVL_HI] : (in_svc == 2'b00));

    assign vec_calc = VEC_BASE + VEC_W'(win_idx) * VEC_STEP;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (reti_done)                   state_d = ST_GAP;
                else if (insn_bound && eligible) state_d = ST_CALL;
            end
            ST_CALL: begin
                if (call_ack) state_d = ST_IDLE;
            end
            ST_GAP: begin
                if (reti_done)       state_d = ST_GAP;
                else if (insn_bound) state_d = eligible ? ST_CALL : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign load_call = (state_d == ST_CALL) && (state_q != ST_CALL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_q    <= '0;
            lvl_hi_q <= 1'b0;
        end else if (load_call) begin
            vec_q    <= vec_calc;
            lvl_hi_q <= win_hi;
        end
    end

    assign take_irq = (state_q == ST_CALL);
    assign vec_addr = vec_q;

endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
    parameter int NUM_SRC = 11,
    parameter int VEC_W   = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               glb_en,
    input logic [NUM_SRC-1:0] req_pend,
    input logic [NUM_SRC-1:0] req_en,
    input logic [NUM_SRC-1:0] req_hi,
    input logic               insn_bound,
    input logic               reti_done,
    input logic               call_ack,
    input logic               take_irq,
    input logic [VEC_W-1:0]   vec_addr,
    input logic [1:0]         in_svc
);

    // R7
    hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_irq && !call_ack) |=> (take_irq && $stable(vec_addr)));

    // R7
    drop_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_irq && call_ack) |=> !take_irq);

    // R6
    start_on_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(take_irq) |-> $past(insn_bound));

    // R11
    no_start_with_reti_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(take_irq) |-> !$past(reti_done));

    // R9
    no_nest_over_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(take_irq) |-> !$past(in_svc[1]));

    // R8
    svc_set_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_irq && call_ack) |=> (in_svc != 2'b00));

    // R10
    reti_clears_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reti_done && !take_irq && in_svc == 2'b11) |=> (in_svc == 2'b01));

    // R5
    vector_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |-> (vec_addr[2:0] == 3'b011 && vec_addr <= 16'h0053
                      && vec_addr != 16'h0043));

endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_chk (.*);

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NS = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          glb_en = 1'b0;
    logic [NS-1:0] req_pend = '0;
    logic [NS-1:0] req_en = '0;
    logic [NS-1:0] req_hi = '0;
    logic          insn_bound = 1'b0;
    logic          reti_done = 1'b0;
    logic          call_ack = 1'b0;
    logic          take_irq;
    logic [15:0]   vec_addr;
    logic [1:0]    in_svc;

    int n_vec = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_prio_ctrl u_irq_prio_ctrl (
        .clk(clk), .rst_n(rst_n), .glb_en(glb_en),
        .req_pend(req_pend), .req_en(req_en), .req_hi(req_hi),
        .insn_bound(insn_bound), .reti_done(reti_done), .call_ack(call_ack),
        .take_irq(take_irq), .vec_addr(vec_addr), .in_svc(in_svc)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bound();
        insn_bound = 1'b1;
        step(1);
        insn_bound = 1'b0;
    endtask

    task automatic ack();
        call_ack = 1'b1;
        step(1);
        call_ack = 1'b0;
    endtask

    // a return completes on an instruction boundary
    task automatic reti();
        reti_done  = 1'b1;
        insn_bound = 1'b1;
        step(1);
        reti_done  = 1'b0;
        insn_bound = 1'b0;
    endtask

    task automatic clear_src();
        req_pend = '0;
        req_en   = '0;
        req_hi   = '0;
        step(1);
    endtask

    task automatic t_reset();
        check("R1 take", 32'(take_irq), 32'd0);
        check("R1 in_svc", 32'(in_svc), 32'd0);
        check("R1 vec", 32'(vec_addr), 32'h0000);
    endtask

    task automatic t_gating();
        glb_en = 1'b1;
        req_pend = 11'b00000000100;
        req_en   = '0;
        bound();
        check("R2 enable clear", 32'(take_irq), 32'd0);
        req_pend = '1;
        req_en   = '1;
        glb_en   = 1'b0;
        bound();
        check("R2 global off", 32'(take_irq), 32'd0);
        glb_en   = 1'b1;
        req_pend = 11'b00100000000;
        req_en   = 11'b00100000000;
        req_hi   = 11'b00100000000;
        bound();
        check("R2 reserved index 8", 32'(take_irq), 32'd0);
        clear_src();
    endtask

    task automatic t_boundary();
        req_pend = 11'b00000000010;
        req_en   = 11'b00000000010;
        step(5);
        check("R6 no boundary", 32'(take_irq), 32'd0);
        bound();
        check("R6 taken after boundary", 32'(take_irq), 32'd1);
        check("R5 vec idx1", 32'(vec_addr), 32'h000B);
        ack();
        check("R7 drop after ack", 32'(take_irq), 32'd0);
        check("R8 low bit", 32'(in_svc), 32'b01);
        clear_src();
        reti();
        check("R10 cleared", 32'(in_svc), 32'b00);
        step(1);
    endtask

    task automatic t_same_level();
        req_pend = 11'b00000101000;
        req_en   = 11'b00000101000;
        bound();
        check("R4 lowest index", 32'(vec_addr), 32'h001B);
        ack();
        check("R8 low set", 32'(in_svc), 32'b01);
        clear_src();
        reti();
        step(1);
    endtask

    task automatic t_level();
        req_pend = 11'b00001000010;
        req_en   = 11'b00001000010;
        req_hi   = 11'b00001000000;
        bound();
        check("R3 high wins", 32'(vec_addr), 32'h0033);
        req_pend = '0;
        step(3);
        check("R7 take held", 32'(take_irq), 32'd1);
        check("R7 vec held", 32'(vec_addr), 32'h0033);
        ack();
        check("R8 high set", 32'(in_svc), 32'b10);
        req_pend = 11'b00000000001;
        req_en   = 11'b00000000001;
        req_hi   = 11'b00000000001;
        bound();
        check("R9 high blocks high", 32'(take_irq), 32'd0);
        clear_src();
        reti();
        check("R10 high cleared", 32'(in_svc), 32'b00);
        step(1);
    endtask

    task automatic t_nest();
        req_pend = 11'b00000010000;
        req_en   = 11'b00000010000;
        bound();
        check("R5 vec idx4", 32'(vec_addr), 32'h0023);
        ack();
        req_pend = 11'b00000000001;
        req_en   = 11'b00000000001;
        bound();
        check("R9 low blocked", 32'(take_irq), 32'd0);
        req_pend = 11'b10000000001;
        req_en   = 11'b10000000001;
        req_hi   = 11'b10000000000;
        bound();
        check("R9 high nests", 32'(take_irq), 32'd1);
        check("R5 vec idx10", 32'(vec_addr), 32'h0053);
        ack();
        check("R8 both set", 32'(in_svc), 32'b11);
        req_pend = 11'b00000000001;
        req_en   = 11'b00000000001;
        req_hi   = '0;
        reti();
        check("R10 keeps low", 32'(in_svc), 32'b01);
        reti();
        check("R10 low cleared", 32'(in_svc), 32'b00);
        check("R11 no take with reti", 32'(take_irq), 32'd0);
        step(2);
        check("R11 waits for boundary", 32'(take_irq), 32'd0);
        bound();
        check("R11 taken after one insn", 32'(take_irq), 32'd1);
        check("R5 vec idx0", 32'(vec_addr), 32'h0003);
        ack();
        clear_src();
        reti();
        step(1);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        step(3);
        t_reset();
        rst_n = 1'b1;
        step(2);
        t_reset();
        t_gating();
        t_boundary();
        t_same_level();
        t_level();
        t_nest();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule